// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Double-Buffered Compare Value

This block is one 16-bit timer channel built around a free-running up-counter. The counter restarts from zero after it reaches a programmable limit, and that wrap is the channel's update event. In output mode, software writes a compare value. Depending on a preload-enable bit, the value goes straight into the active compare register, or it waits in a holding register until the next update event. Whenever the running counter equals the active compare value, the channel applies the selected action (set, clear, toggle or nothing) to an internal reference level. Polarity and enable bits shape that level before it reaches the output pin.

In input mode, the same channel register records the counter value when a chosen edge arrives on the capture input, after a two-stage synchronizer. Status flags mark update events, compare matches or captures, and captures that overwrite an unread result. Two flags can each raise the interrupt line. Software can also force an update event or a capture/compare event through the register port.

The register port is a single-cycle write strobe with a combinational read.

Top module: `cc_channel`

## Requirements
- R1: After reset the following hold: the channel value (address 8) and active compare value (address 9) read 0x0000, the limit (address 7) reads 0xFFFF, the counter (address 6) and status (address 2) read 0, and both `cmp_out` and `irq` are 0.
- R2: In output mode (address 4 bits [1:0] = 00) with preload disabled (address 4 bit 5 = 0), a write to address 8 appears in the active compare value on the next cycle.
- R3: In output mode with preload enabled, a write to address 8 is held, and reads of address 8 return it. The active compare value does not change until an update event.
- R4: While run (address 0 bit 0) is 1, the counter increments once per cycle. When it equals the limit, it returns to 0 on the next cycle; this is an update event and sets the update flag (status bit 0).
- R5: Address 4 bits [4:2] select the match action on the reference level: 0 = hold, 1 = set, 2 = clear, 3 = toggle. The action applies on each cycle where the running counter equals the active compare value in output mode.
- R6: Address 5 bit 0 is the enable and bit 1 is the polarity. `cmp_out` equals the reference level XOR polarity when enabled in output mode, and is 0 otherwise, including in input mode.
- R7: In input mode (address 4 bits [1:0] ≠ 00) with enable set, a rising edge of `cap_in` (polarity 0) or a falling edge (polarity 1) copies the counter into the channel value three clocks after the pin changes. The opposite edge is ignored.
- R8: A compare match in output mode, or a capture in input mode, sets the capture/compare flag (status bit 1). A capture while that flag is already set also sets the overcapture flag (status bit 2).
- R9: Writing address 2 clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A flag being set by hardware in the same cycle stays set.
- R10: Writing address 3 with bit 0 set forces an update event: the counter goes to 0, the update flag is set and the preload is transferred. Bit 1 set forces a capture/compare event, which in input mode captures the counter.
- R11: `irq` is high when (update flag AND address 1 bit 0) OR (capture/compare flag AND address 1 bit 1).
- R12: In input mode, writes to address 8 are ignored, and reads of address 8 return the last captured value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cap_in | input | 1 | Capture input, asynchronous |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus issues at most one write per cycle and that software does not change the channel mode in the same cycle as an event it expects to be checked. They also assume that `cap_in` is held steady for at least two clocks between edges, so the synchronizer sees every transition. The stimulus meets these assumptions as follows:
- Every write is a single-cycle strobe.
- The mode changes only while the counter is stopped.
- After each change of the capture pin, the bench waits four clocks before reading.

Counter runs use fixed cycle counts, so the match and wrap points fall on known counter values.

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          cap_in,
  output logic          cmp_out,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_IEN  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [AW-1:0] A_EVT  = AW'(3);
  localparam logic [AW-1:0] A_MODE = AW'(4);
  localparam logic [AW-1:0] A_PIN  = AW'(5);
  localparam logic [AW-1:0] A_CNT  = AW'(6);
  localparam logic [AW-1:0] A_LIM  = AW'(7);
  localparam logic [AW-1:0] A_CCR  = AW'(8);
  localparam logic [AW-1:0] A_ACT  = AW'(9);

  logic         run_q, pe_q, en_q, pol_q, ref_q;
  logic         upd_f, cc_f, ovr_f;
  logic [1:0]   ie_q, msel_q;
  logic [2:0]   ocm_q, sync_q;
  logic [W-1:0] cnt_q, lim_q, pre_q, act_q;

  logic is_in, sw_upd, sw_cc, wrap, uev, match, cap, cc_evt;
  logic sig_now, sig_old;

  wire wr_stat = bus_we && bus_addr == A_STAT;
  wire wr_evt  = bus_we && bus_addr == A_EVT;
  wire wr_cnt  = bus_we && bus_addr == A_CNT;
  wire wr_ccr  = bus_we && bus_addr == A_CCR;

  assign is_in   = msel_q != 2'b00;
  assign sw_upd  = wr_evt && bus_wdata[0];
  assign sw_cc   = wr_evt && bus_wdata[1];
  assign wrap    = run_q && cnt_q == lim_q;
  assign uev     = wrap || sw_upd;
  assign match   = run_q && !is_in && cnt_q == act_q;
  assign sig_now = sync_q[1] ^ pol_q;
  assign sig_old = sync_q[2] ^ pol_q;
  assign cap     = is_in && ((en_q && sig_now && !sig_old) || sw_cc);
  assign cc_evt  = cap || (!is_in && (match || sw_cc));

  assign cmp_out = en_q && !is_in && (ref_q ^ pol_q);
  assign irq     = (upd_f && ie_q[0]) || (cc_f && ie_q[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= '0;
      msel_q <= '0;
      ocm_q  <= '0;
      pe_q   <= 1'b0;
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      lim_q  <= '1;
    end else if (bus_we) begin
      case (bus_addr)
        A_CTRL: run_q <= bus_wdata[0];
        A_IEN:  ie_q  <= bus_wdata[1:0];
        A_MODE: begin
          msel_q <= bus_wdata[1:0];
          ocm_q  <= bus_wdata[4:2];
          pe_q   <= bus_wdata[5];
        end
        A_PIN: begin
          en_q  <= bus_wdata[0];
          pol_q <= bus_wdata[1];
        end
        A_LIM:  lim_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= bus_wdata;
    else if (uev)     cnt_q <= '0;
    else if (run_q)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_ccr && !is_in) pre_q <= bus_wdata;
      if (cap)                              act_q <= cnt_q;
      else if (!is_in && wr_ccr && !pe_q)   act_q <= bus_wdata;
      else if (!is_in && uev && pe_q)       act_q <= pre_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_f <= 1'b0;
      cc_f  <= 1'b0;
      ovr_f <= 1'b0;
    end else begin
      upd_f <= uev    || (wr_stat ? (upd_f && bus_wdata[0]) : upd_f);
      cc_f  <= cc_evt || (wr_stat ? (cc_f  && bus_wdata[1]) : cc_f);
      ovr_f <= (cap && cc_f) || (wr_stat ? (ovr_f && bus_wdata[2]) : ovr_f);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], cap_in};
      if (match) begin
        case (ocm_q)
          3'd1:    ref_q <= 1'b1;
          3'd2:    ref_q <= 1'b0;
          3'd3:    ref_q <= !ref_q;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0]   = run_q;
      A_IEN:  bus_rdata[1:0] = ie_q;
      A_STAT: bus_rdata[2:0] = {ovr_f, cc_f, upd_f};
      A_MODE: bus_rdata[5:0] = {pe_q, ocm_q, msel_q};
      A_PIN:  bus_rdata[1:0] = {pol_q, en_q};
      A_CNT:  bus_rdata      = cnt_q;
      A_LIM:  bus_rdata      = lim_q;
      A_CCR:  bus_rdata      = is_in ? act_q : pre_q;
      A_ACT:  bus_rdata      = act_q;
      default: bus_rdata     = '0;
    endcase
  end
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic          cmp_out,
  input logic [1:0]    msel_q,
  input logic          pe_q,
  input logic          en_q,
  input logic          run_q,
  input logic [W-1:0]  cnt_q,
  input logic [W-1:0]  lim_q,
  input logic [W-1:0]  act_q,
  input logic          upd_f,
  input logic          cc_f,
  input logic          ovr_f,
  input logic          uev,
  input logic          cap
);
  localparam logic [AW-1:0] A_CNT = AW'(6);
  localparam logic [AW-1:0] A_CCR = AW'(8);

  assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CCR && msel_q == 2'b00 && !pe_q)
      |=> act_q == $past(bus_wdata));

  assert_preload_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msel_q == 2'b00 && pe_q && !uev) |=> $stable(act_q));

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == lim_q && !(bus_we && bus_addr == A_CNT))
      |=> (cnt_q == '0 && upd_f));

  assert_pin_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_out |-> (en_q && msel_q == 2'b00));

  assert_overcapture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && cc_f) |=> ovr_f);

  assert_flag_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uev |=> upd_f);

  assert_input_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msel_q != 2'b00 && bus_we && bus_addr == A_CCR && !cap) |=> $stable(act_q));
endmodule

bind cc_channel cc_channel_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cmp_out(cmp_out), .msel_q(msel_q), .pe_q(pe_q),
  .en_q(en_q), .run_q(run_q), .cnt_q(cnt_q), .lim_q(lim_q), .act_q(act_q),
  .upd_f(upd_f), .cc_f(cc_f), .ovr_f(ovr_f), .uev(uev), .cap(cap)
);

// File: tb/tb_cc_channel.sv
module tb_cc_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic        cmp_out, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cc_channel dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cmp_out(cmp_out), .irq(irq)
  );

  // op: 0 write, 1 read-compare, 2 idle cycles, 3 drive cap_in, 4 check cmp_out, 5 check irq
  function automatic logic [43:0] v(input int op, input int a, input int d, input int e, input int r);
    return {op[3:0], a[3:0], d[15:0], e[15:0], r[3:0]};
  endfunction

  localparam int NV = 110;
  localparam logic [43:0] TBL [NV] = '{
    v(1,8,0,0,1),            // R1 channel value after reset
    v(1,7,0,16'hFFFF,1),     // R1 limit after reset
    v(0,4,0,0,0),
    v(0,8,16'h1234,0,0),
    v(1,9,0,16'h1234,2),     // R2 direct load
    v(0,4,16'h20,0,0),
    v(0,8,16'h5555,0,0),
    v(1,8,0,16'h5555,3),     // R3 holding register readback
    v(1,9,0,16'h1234,3),     // R3 active unchanged
    v(0,3,1,0,0),
    v(1,9,0,16'h5555,10),    // R10 forced update transfers
    v(1,2,0,1,10),           // R10 update flag
    v(0,2,0,0,0),
    v(1,2,0,0,9),            // R9 clear by zero
    v(0,7,9,0,0),
    v(0,4,4,0,0),
    v(0,8,3,0,0),
    v(0,5,1,0,0),
    v(4,0,0,0,5),            // R5 level before any match
    v(0,0,1,0,0),
    v(2,0,14,0,0),
    v(0,0,0,0,0),
    v(1,6,0,5,4),            // R4 count with wrap at 9
    v(1,2,0,3,8),            // R8 match flag plus update flag
    v(4,0,0,1,5),            // R5 set on match
    v(0,5,3,0,0),
    v(4,0,0,0,6),            // R6 inverted
    v(0,5,0,0,0),
    v(4,0,0,0,6),            // R6 disabled
    v(0,5,1,0,0),
    v(4,0,0,1,6),            // R6 re-enabled
    v(0,2,2,0,0),
    v(1,2,0,2,9),            // R9 one keeps a flag
    v(0,2,0,0,0),
    v(0,4,16'h0C,0,0),
    v(0,0,1,0,0),
    v(2,0,14,0,0),
    v(0,0,0,0,0),
    v(1,6,0,0,4),            // R4 counter position
    v(4,0,0,0,5),            // R5 toggle
    v(0,0,1,0,0),
    v(2,0,4,0,0),
    v(0,0,0,0,0),
    v(4,0,0,1,5),            // R5 toggle again
    v(0,4,8,0,0),
    v(0,0,1,0,0),
    v(2,0,14,0,0),
    v(0,0,0,0,0),
    v(4,0,0,0,5),            // R5 clear on match
    v(0,4,4,0,0),
    v(0,0,1,0,0),
    v(2,0,4,0,0),
    v(0,0,0,0,0),
    v(4,0,0,1,5),            // R5 set on match
    v(0,4,0,0,0),
    v(0,0,1,0,0),
    v(2,0,14,0,0),
    v(0,0,0,0,0),
    v(4,0,0,1,5),            // R5 hold
    v(0,2,0,0,0),
    v(0,4,16'h20,0,0),
    v(0,8,7,0,0),
    v(1,9,0,3,3),            // R3 held value
    v(0,0,1,0,0),
    v(2,0,4,0,0),
    v(0,0,0,0,0),
    v(1,9,0,3,3),            // R3 no wrap yet
    v(0,0,1,0,0),
    v(2,0,14,0,0),
    v(0,0,0,0,0),
    v(1,9,0,7,3),            // R3 transferred on wrap
    v(0,1,1,0,0),
    v(5,0,0,1,11),           // R11 update source
    v(0,2,2,0,0),
    v(5,0,0,0,11),           // R11 masked flag
    v(0,1,2,0,0),
    v(5,0,0,1,11),           // R11 compare source
    v(0,2,0,0,0),
    v(5,0,0,0,11),           // R11 cleared
    v(0,1,0,0,0),
    v(0,4,1,0,0),
    v(0,5,1,0,0),
    v(0,7,16'hFFFF,0,0),
    v(0,6,16'h100,0,0),
    v(4,0,0,0,6),            // R6 pin low in input mode
    v(0,8,16'hBEEF,0,0),
    v(1,8,0,7,12),           // R12 write ignored
    v(3,0,1,0,0),
    v(2,0,4,0,0),
    v(1,8,0,16'h100,7),      // R7 rising capture
    v(1,2,0,2,8),            // R8 capture flag
    v(0,6,16'h150,0,0),
    v(3,0,0,0,0),
    v(2,0,4,0,0),
    v(1,8,0,16'h100,7),      // R7 falling ignored
    v(3,0,1,0,0),
    v(2,0,4,0,0),
    v(1,8,0,16'h150,7),      // R7 second capture
    v(1,2,0,6,8),            // R8 overcapture
    v(0,2,0,0,0),
    v(0,6,16'h200,0,0),
    v(0,5,3,0,0),
    v(3,0,0,0,0),
    v(2,0,4,0,0),
    v(1,8,0,16'h200,7),      // R7 falling capture
    v(1,2,0,2,8),            // R8 single capture
    v(0,6,16'h300,0,0),
    v(0,3,2,0,0),
    v(1,8,0,16'h300,10),     // R10 forced capture
    v(1,2,0,6,10)            // R10 forced capture overcaptures
  };

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input int r, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", r, what, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input int r);
    bus_addr = a;
    #1 check(bus_rdata, e, r, "read");
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the pins
    #1 check({15'd0, cmp_out}, 16'd0, 1, "cmp_out");
    check({15'd0, irq}, 16'd0, 1, "irq");
    rd(4'd2, 16'd0, 1);
    rd(4'd6, 16'd0, 1);
    rd(4'd9, 16'd0, 1);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] t;
      t = TBL[i];
      case (t[43:40])
        4'd0: wr(t[39:36], t[35:20]);
        4'd1: rd(t[39:36], t[19:4], int'(t[3:0]));
        4'd2: repeat (int'(t[35:20])) @(negedge clk);
        4'd3: begin cap_in = t[20]; @(negedge clk); end
        4'd4: begin #1 check({15'd0, cmp_out}, t[19:4], int'(t[3:0]), "cmp_out"); @(negedge clk); end
        default: begin #1 check({15'd0, irq}, t[19:4], int'(t[3:0]), "irq"); @(negedge clk); end
      endcase
    end

    // R1 reset from a busy state
    wr(4'd4, 16'h4);
    wr(4'd1, 16'h3);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check({15'd0, cmp_out}, 16'd0, 1, "cmp_out after reset");
    check({15'd0, irq}, 16'd0, 1, "irq after reset");
    rd(4'd8, 16'd0, 1);
    rd(4'd7, 16'hFFFF, 1);
    rd(4'd2, 16'd0, 1);
    rd(4'd4, 16'd0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule